// File: doc/BRIEF.md
# Serial Address to Pulse-Position Converter

This block takes a packet header address that arrives one bit per clock, least significant bit first, and gathers it into a parallel word. Once the last bit is in, it plays out a frame of 2^N clock slots. Exactly one slot of that frame carries a single-cycle pulse. The pulse sits in the slot whose index equals the binary value of the address, so each address bit of weight 2^i moves the pulse 2^i slots later than the start of the frame.

A downstream matcher needs only one AND against a stored slot pattern to test the address. That pattern may hold pulses for several addresses. The converter therefore presents the frame-start strobe, the running slot index and the pulse stream side by side. It also presents the gathered address, which stays stable between headers.

A header starts with a strobe cycle, and the first address bit is on the serial input in that same cycle. While a header is being gathered or a frame is being played out, the converter raises a busy flag and ignores further strobes. The header source waits for busy to drop before it sends again.

Top module: `ppm_addr_encoder`

## Requirements
- R1: While reset is held and after it is released, `busy`, `frame_start` and `ppm_pulse` are 0, and `slot_idx` and `addr_word` are 0.
- R2: A strobe on `hdr_start` while `busy` is 0 is accepted. The bit on `ser_bit` in that cycle is a_0, and the next ADDR_W-1 cycles carry a_1 to a_(ADDR_W-1). The address value is the sum of a_i * 2^i.
- R3: Every frame holds exactly one cycle with `ppm_pulse` at 1.
- R4: The pulse falls in the slot whose index equals the address value, and address 0 puts it in slot 0.
- R5: `frame_start` is 1 in the cycle after the last address bit, and only then. `slot_idx` is 0 in that cycle and rises by one per cycle up to 2^ADDR_W-1.
- R6: `addr_word` takes the new address in the frame-start cycle. It keeps its previous value at every other time, including while the next header is being gathered.
- R7: `busy` is 1 from the cycle after an accepted strobe through the last slot of the frame. A strobe seen while `busy` is 1 is ignored and changes neither the frame in progress nor `addr_word`.
- R8: In the cycle after the last slot, `busy` is 0 and a new strobe is accepted at once, so frames can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered clock; one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_start | input | 1 | Header start strobe, set in the cycle that carries a_0 |
| ser_bit | input | 1 | Serial address bit, least significant first |
| addr_word | output | ADDR_W | Most recently gathered address |
| frame_start | output | 1 | Marks slot 0 of a pulse-position frame |
| slot_idx | output | ADDR_W | Index of the current slot; 0 when no frame is running |
| ppm_pulse | output | 1 | Pulse-position output, high in one slot per frame |
| busy | output | 1 | Header being gathered or frame being played out |

## Verification
The assertions assume that a header source never leaves a header half sent. Once a strobe is accepted, the next ADDR_W-1 serial bits are taken as the address whatever is on the line. The stimulus therefore always drives a full header after each accepted strobe, and it issues a new strobe only in a cycle where busy has been observed low. Strobes sent on purpose during a frame are the only exception, and they test that the converter ignores a request it is not ready to accept.

// File: rtl/ppm_conv_pkg.sv
package ppm_conv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_EMIT    = 2'd2
  } conv_state_t;

  // Delay in slots contributed by an address: each set bit i adds 2^i.
  function automatic int unsigned weighted_delay(input logic [31:0] bits,
                                                 input int unsigned width);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < width && bits[i]) acc += (32'd1 << i);
    end
    return acc;
  endfunction

  // Number of slots in one frame for a given address width.
  function automatic int unsigned frame_slots(input int unsigned width);
    return 32'd1 << width;
  endfunction

endpackage

// File: rtl/hdr_shift_in.sv
module hdr_shift_in #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_bit,
  input  logic         ser_bit,
  output logic [W-1:0] word_next,
  output logic         last_bit
);
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(W - 1);

  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;

  // Bits enter at the top and move down, so the first bit ends in bit 0.
  generate
    if (W == 1) begin : g_single
      assign word_next = ser_bit;
    end else begin : g_multi
      assign word_next = {ser_bit, sh_q[W-1:1]};
    end
  endgenerate

  assign last_bit = take_bit && (cnt_q == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (take_bit) begin
      sh_q  <= word_next;
      cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ppm_slot_timer.sv
module ppm_slot_timer #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         running,
  output logic [W-1:0] slot,
  output logic         frame_first,
  output logic         frame_last
);
  localparam logic [W-1:0] SLOT_MAX = {W{1'b1}};

  logic         run_q;
  logic [W-1:0] slot_q;

  assign running     = run_q;
  assign slot        = slot_q;
  assign frame_first = run_q && (slot_q == '0);
  assign frame_last  = run_q && (slot_q == SLOT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      slot_q <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      slot_q <= '0;
    end else if (run_q) begin
      if (slot_q == SLOT_MAX) begin
        run_q  <= 1'b0;
        slot_q <= '0;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ppm_pulse_gen.sv
module ppm_pulse_gen #(
  parameter int unsigned W = 5
) (
  input  logic         running,
  input  logic [W-1:0] slot,
  input  logic [W-1:0] addr,
  output logic         pulse
);
  import ppm_conv_pkg::*;

  logic [W-1:0] target_slot;

  assign target_slot = W'(weighted_delay(32'(addr), W));
  assign pulse       = running && (slot == target_slot);
endmodule

// File: rtl/ppm_addr_encoder.sv
module ppm_addr_encoder #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_start,
  input  logic              ser_bit,
  output logic [ADDR_W-1:0] addr_word,
  output logic              frame_start,
  output logic [ADDR_W-1:0] slot_idx,
  output logic              ppm_pulse,
  output logic              busy
);
  import ppm_conv_pkg::*;

  conv_state_t       st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] word_next_w;

  // Named internal events, used by the bound checker.
  logic accept_w;
  logic take_bit_w;
  logic last_bit_w;
  logic running_w;
  logic frame_first_w;
  logic frame_last_w;

  assign accept_w   = (st_q == ST_IDLE) && hdr_start;
  assign take_bit_w = accept_w || (st_q == ST_COLLECT);

  hdr_shift_in #(.W(ADDR_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_bit  (take_bit_w),
    .ser_bit   (ser_bit),
    .word_next (word_next_w),
    .last_bit  (last_bit_w)
  );

  ppm_slot_timer #(.W(ADDR_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (last_bit_w),
    .running     (running_w),
    .slot        (slot_idx),
    .frame_first (frame_first_w),
    .frame_last  (frame_last_w)
  );

  ppm_pulse_gen #(.W(ADDR_W)) u_pulse (
    .running (running_w),
    .slot    (slot_idx),
    .addr    (addr_q),
    .pulse   (ppm_pulse)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (accept_w) st_d = last_bit_w ? ST_EMIT : ST_COLLECT;
      ST_COLLECT: if (last_bit_w) st_d = ST_EMIT;
      ST_EMIT:    if (frame_last_w) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (last_bit_w) addr_q <= word_next_w;
    end
  end

  assign addr_word   = addr_q;
  assign frame_start = frame_first_w;
  assign busy        = (st_q != ST_IDLE);
endmodule

// File: rtl/ppm_addr_encoder_chk.sv
module ppm_addr_encoder_chk #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              busy,
  input logic              frame_start,
  input logic              frame_last,
  input logic [ADDR_W-1:0] slot_idx,
  input logic              ppm_pulse,
  input logic [ADDR_W-1:0] addr_word
);
  logic [1:0] seen_q;
  logic [1:0] seen_now;

  assign seen_now = (frame_start ? 2'd0 : seen_q) + {1'b0, ppm_pulse};

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 2'd0;
    else if (seen_q != 2'd3) seen_q <= seen_now;
  end

  a_r3_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |-> (seen_now == 2'd1));

  a_r4_pulse_at_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ppm_pulse |-> (slot_idx == addr_word));

  a_r5_start_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (slot_idx == '0) && busy);

  a_r5_slot_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx != '0) |-> (slot_idx == $past(slot_idx) + 1'b1));

  a_r6_addr_only_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_word) |-> frame_start);

  a_r7_pulse_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ppm_pulse |-> busy);

  a_r2_accept_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  a_r8_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |=> !busy);
endmodule

bind ppm_addr_encoder ppm_addr_encoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (accept_w),
  .busy        (busy),
  .frame_start (frame_start),
  .frame_last  (frame_last_w),
  .slot_idx    (slot_idx),
  .ppm_pulse   (ppm_pulse),
  .addr_word   (addr_word)
);

// File: tb/ppm_addr_encoder_test.sv
`timescale 1ns/1ps
module ppm_addr_encoder_test;
  localparam int N = 5;
  localparam int SLOTS = 1 << N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hdr_start = 1'b0;
  logic         ser_bit = 1'b0;
  logic [N-1:0] addr_word;
  logic         frame_start;
  logic [N-1:0] slot_idx;
  logic         ppm_pulse;
  logic         busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [N-1:0] prev_addr = '0;

  always #4 clk = ~clk;

  ppm_addr_encoder #(.ADDR_W(N)) uut (
    .clk(clk), .rst_n(rst_n), .hdr_start(hdr_start), .ser_bit(ser_bit),
    .addr_word(addr_word), .frame_start(frame_start), .slot_idx(slot_idx),
    .ppm_pulse(ppm_pulse), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Address value computed as a weighted sum of the bits, in bench terms.
  function automatic int value_of(input logic [N-1:0] a);
    int v = 0;
    for (int i = N - 1; i >= 0; i--) v = v * 2 + int'(a[i]);
    return v;
  endfunction

  task automatic send_frame(input int a, input bit inject);
    logic [N-1:0] av;
    int pulses;
    int expect_slot;
    av = a[N-1:0];
    expect_slot = value_of(av);
    check(busy == 1'b0, "R8", "busy before strobe", busy, 0);
    hdr_start = 1'b1;
    ser_bit   = av[0];
    @(negedge clk);
    hdr_start = 1'b0;
    for (int i = 1; i < N; i++) begin
      ser_bit = av[i];
      check(busy == 1'b1, "R7", "busy while gathering", busy, 1);
      check(frame_start == 1'b0, "R5", "no frame start while gathering", frame_start, 0);
      check(addr_word == prev_addr, "R6", "address held while gathering",
            addr_word, prev_addr);
      @(negedge clk);
    end
    ser_bit = 1'b0;
    pulses = 0;
    for (int s = 0; s < SLOTS; s++) begin
      check(frame_start == (s == 0), "R5", "frame start marker", frame_start, s == 0);
      check(slot_idx == s[N-1:0], "R5", "slot index", slot_idx, s);
      check(ppm_pulse == (s == expect_slot), "R4", "pulse position", ppm_pulse,
            s == expect_slot);
      check(addr_word == av, "R6", "address during frame", addr_word, a);
      check(busy == 1'b1, "R7", "busy during frame", busy, 1);
      if (ppm_pulse) pulses++;
      if (inject && s == 2) begin
        hdr_start = 1'b1;
        ser_bit   = 1'b1;
      end
      if (inject && s == 3) begin
        hdr_start = 1'b0;
        ser_bit   = 1'b0;
      end
      @(negedge clk);
    end
    check(pulses == 1, "R3", "pulses per frame", pulses, 1);
    check(busy == 1'b0, "R8", "idle after last slot", busy, 0);
    check(ppm_pulse == 1'b0, "R3", "no pulse after frame", ppm_pulse, 0);
    check(slot_idx == '0, "R5", "slot index after frame", slot_idx, 0);
    prev_addr = av;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(busy == 1'b0 && frame_start == 1'b0 && ppm_pulse == 1'b0, "R1",
          "control outputs in reset", {busy, frame_start, ppm_pulse}, 0);
    check(slot_idx == '0 && addr_word == '0, "R1", "data outputs in reset",
          {slot_idx, addr_word}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && addr_word == '0, "R1", "state after reset",
          {busy, addr_word}, 0);

    // R2 R4: exhaustive sweep, odd addresses get a strobe during the frame (R7)
    for (int a = 0; a < SLOTS; a++) send_frame(a, a[0]);

    // R8: back-to-back extremes
    send_frame(SLOTS - 1, 1'b0);
    send_frame(0, 1'b1);
    send_frame(SLOTS - 1, 1'b0);

    // R6: address held while idle
    repeat (3) @(negedge clk);
    check(addr_word == prev_addr, "R6", "address held while idle", addr_word, prev_addr);
    check(busy == 1'b0, "R7", "stays idle without strobe", busy, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule